// File: doc/BRIEF.md
# NRZI Receive Decoder with Stuffed-Bit Removal

This block sits on the receive side of a low- or full-speed serial bus link, after clock and data recovery. Once per bit time a strobe marks the moment at which the recovered line level is valid. The block compares that sample with the one taken at the previous bit time. A change of level becomes a data 0, and an unchanged level becomes a data 1.

The transmitter forces a transition after every run of six 1s. The block counts consecutive decoded 1s and discards the bit that follows the sixth one. The discarded bit must be a 0 (a level change). If the line does not change in that slot, the block raises a one-cycle stuff-error pulse and abandons the packet.

Packet framing is supplied from outside. A line-state monitor pulses a start input when a packet begins and an end input when it finishes. Between those two pulses the block delivers the recovered bits, each qualified by a one-cycle valid flag. It also reports whether a packet is currently being decoded.

Top module: `nrzi_rx_unstuff`

## Requirements
- R1: A line sample equal to the previous sample decodes as 1, and a sample that differs decodes as 0. The decoded bit appears on `dout` with `dout_vld` high in the clock cycle after the strobe that sampled it.
- R2: On `pkt_start` the remembered line level is set to idle J (`line_j`=1). The first K sample of the packet therefore decodes as 0, and a first J sample decodes as 1.
- R3: The bit that follows six consecutive decoded 1s is removed. No `dout_vld` pulse is produced for it.
- R4: After a removed bit the run of 1s is counted from zero again. Every further run of six 1s is followed by another removed bit.
- R5: If the bit after six consecutive 1s decodes as 1, `stuff_err` is high for exactly one cycle, one cycle after that strobe, and `in_pkt` is low from that same cycle. Later strobes produce no output until the next `pkt_start`.
- R6: Every decoded 0 and every `pkt_start` clears the count of consecutive 1s. Five 1s, a 0 and then 1s give no removed bit until the sixth 1 after the 0.
- R7: Strobes outside a packet (when `in_pkt` is low) produce neither `dout_vld` nor `stuff_err`.
- R8: `pkt_end` drops `in_pkt` in the following cycle. A strobe in the same cycle as `pkt_end` or `pkt_start` is ignored.
- R9: While reset is active and directly after it, `dout`, `dout_vld`, `stuff_err` and `in_pkt` are all 0.
- R10: `dout_vld` and `stuff_err` are never high together. Neither is high in a cycle that does not follow a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | One-cycle pulse marking a bit-time sample point |
| line_j | input | 1 | Recovered line level: 1 = J (idle), 0 = K |
| pkt_start | input | 1 | Pulse from the line-state monitor: a packet begins |
| pkt_end | input | 1 | Pulse from the line-state monitor: the packet ends |
| dout | output | 1 | Recovered data bit |
| dout_vld | output | 1 | `dout` carries a new bit this cycle |
| stuff_err | output | 1 | One-cycle pulse: no transition where a stuffed 0 was due |
| in_pkt | output | 1 | A packet is being decoded |

## Verification
The embedded assertions check a set of local rules on every cycle:
- The run count never exceeds six.
- A valid bit or an error is always preceded by an accepted strobe.
- An error pulse always follows a full run of 1s and coincides with the end of the packet.
- Valid and error never coincide.
- The remembered level is J after a packet start.

Whether the right bits come out in the right order is shown only by the bench's scenarios. These cover stuffed bits removed at repeated positions, the counter reset by a 0, the first-bit reference to J, the abort after a missing stuff bit, and strobes ignored outside a packet or at its edges. A behavioural model compares every output on every clock.

// File: rtl/nrzi_rx_pkg.sv
package nrzi_rx_pkg;

  typedef enum logic {RX_IDLE, RX_ACTIVE} rx_state_e;

  localparam logic LVL_J = 1'b1;

  // Unchanged level means a 1, a level change means a 0.
  function automatic logic nrzi_bit(input logic prev_lvl, input logic cur_lvl);
    return prev_lvl ~^ cur_lvl;
  endfunction

  // Length of the run of 1s after one more decoded bit.
  function automatic int unsigned run_next(input int unsigned cnt, input logic bit_in);
    return bit_in ? cnt + 1 : 0;
  endfunction

endpackage

// File: rtl/nrzi_slicer.sv
module nrzi_slicer
  import nrzi_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic take,
  input  logic line_j,
  output logic dec_bit
);
  logic prev_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prev_lvl <= LVL_J;
    else if (init)   prev_lvl <= LVL_J;
    else if (take)   prev_lvl <= line_j;
  end

  assign dec_bit = nrzi_bit(prev_lvl, line_j);

  // R2: a packet start leaves J as the reference level
  p_prev_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> prev_lvl == LVL_J);

endmodule

// File: rtl/run_tracker.sv
module run_tracker
  import nrzi_rx_pkg::*;
#(
  parameter int RUN_LEN = 6,
  localparam int CNT_W = $clog2(RUN_LEN + 1)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             take,
  input  logic             dec_bit,
  output logic             stuff_slot,
  output logic [CNT_W-1:0] run_cnt
);
  assign stuff_slot = (run_cnt == CNT_W'(RUN_LEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_cnt <= '0;
    else if (clear)      run_cnt <= '0;
    else if (take) begin
      if (stuff_slot)    run_cnt <= '0;
      else               run_cnt <= CNT_W'(run_next(int'(run_cnt), dec_bit));
    end
  end

  // R3: the run count stops at the stuff slot
  p_run_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= CNT_W'(RUN_LEN));

  // R6: a decoded 0 outside the stuff slot restarts the run
  p_zero_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !clear && !stuff_slot && !dec_bit) |=> run_cnt == '0);

endmodule

// File: rtl/rx_out_stage.sv
module rx_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic deliver,
  input  logic abort,
  input  logic dec_bit,
  output logic dout,
  output logic dout_vld,
  output logic stuff_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout      <= 1'b0;
      dout_vld  <= 1'b0;
      stuff_err <= 1'b0;
    end else begin
      dout_vld  <= deliver;
      stuff_err <= abort;
      if (deliver) dout <= dec_bit;
    end
  end

  // R10: data and error are never flagged together
  p_vld_err_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(dout_vld && stuff_err));

endmodule

// File: rtl/nrzi_rx_unstuff.sv
module nrzi_rx_unstuff
  import nrzi_rx_pkg::*;
#(
  parameter int RUN_LEN = 6
)(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic line_j,
  input  logic pkt_start,
  input  logic pkt_end,
  output logic dout,
  output logic dout_vld,
  output logic stuff_err,
  output logic in_pkt
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);

  rx_state_e        state;
  logic             take;
  logic             dec_bit;
  logic             stuff_slot;
  logic [CNT_W-1:0] run_cnt;
  logic             drop_evt;
  logic             err_evt;
  logic             deliver_evt;

  // Named internal events
  assign take        = bit_stb && (state == RX_ACTIVE) && !pkt_start && !pkt_end;
  assign drop_evt    = take && stuff_slot && !dec_bit;
  assign err_evt     = take && stuff_slot && dec_bit;
  assign deliver_evt = take && !stuff_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  state <= RX_IDLE;
    else if (pkt_start)          state <= RX_ACTIVE;
    else if (pkt_end || err_evt) state <= RX_IDLE;
  end

  assign in_pkt = (state == RX_ACTIVE);

  nrzi_slicer u_slicer (
    .clk     (clk),
    .rst_n   (rst_n),
    .init    (pkt_start),
    .take    (take),
    .line_j  (line_j),
    .dec_bit (dec_bit)
  );

  run_tracker #(.RUN_LEN(RUN_LEN)) u_run (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (pkt_start),
    .take       (take),
    .dec_bit    (dec_bit),
    .stuff_slot (stuff_slot),
    .run_cnt    (run_cnt)
  );

  rx_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .deliver   (deliver_evt),
    .abort     (err_evt),
    .dec_bit   (dec_bit),
    .dout      (dout),
    .dout_vld  (dout_vld),
    .stuff_err (stuff_err)
  );

  // R1 / R10: a valid bit follows an accepted strobe
  p_vld_after_stb_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dout_vld |-> ($past(bit_stb) && $past(in_pkt)));

  // R5: an error follows a full run and ends the packet
  p_err_after_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_err |-> ($past(run_cnt) == CNT_W'(RUN_LEN) && !in_pkt));

  // R5: the error is a single-cycle pulse
  p_err_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_err |=> !stuff_err);

  // R3: a dropped stuffed bit yields no valid
  p_drop_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> !dout_vld && !stuff_err);

  // R7: nothing comes out while idle
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_pkt |=> !dout_vld && !stuff_err);

  // R8: end of packet drops in_pkt unless a start coincides
  p_end_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end && !pkt_start) |=> !in_pkt);

  // R6: a start clears the run count
  p_start_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |=> in_pkt && run_cnt == '0);

endmodule

// File: tb/nrzi_rx_unstuff_test.sv
`timescale 1ns/1ps
module nrzi_rx_unstuff_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_stb = 1'b0;
  logic line_j = 1'b1;
  logic pkt_start = 1'b0;
  logic pkt_end = 1'b0;
  logic dout, dout_vld, stuff_err, in_pkt;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string cur_req = "R9";

  always #2.5 clk = ~clk;

  nrzi_rx_unstuff uut (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .line_j(line_j),
    .pkt_start(pkt_start), .pkt_end(pkt_end),
    .dout(dout), .dout_vld(dout_vld), .stuff_err(stuff_err), .in_pkt(in_pkt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int  m_prev = 1;
  int  m_ones = 0;
  bit  m_act  = 0;
  bit  e_vld = 0, e_err = 0, e_dout = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_prev = 1; m_ones = 0; e_vld = 0; e_err = 0; e_dout = 0;
    end else begin
      e_vld = 0; e_err = 0;
      if (pkt_start) begin
        m_act = 1; m_prev = 1; m_ones = 0;
      end else if (pkt_end) begin
        m_act = 0;
      end else if (bit_stb && m_act) begin
        int d;
        d = (int'(line_j) == m_prev) ? 1 : 0;
        m_prev = int'(line_j);
        if (m_ones == 6) begin
          m_ones = 0;
          if (d == 1) begin e_err = 1; m_act = 0; end
        end else begin
          e_vld = 1; e_dout = d[0];
          m_ones = (d == 1) ? m_ones + 1 : 0;
        end
      end
    end
  end

  // Per-cycle comparison and capture, away from the active edge
  logic rxq[$];
  int   err_seen = 0;
  always @(negedge clk) begin
    chk({cur_req, " dout_vld"}, int'(dout_vld), int'(e_vld));
    chk({cur_req, " stuff_err"}, int'(stuff_err), int'(e_err));
    chk({cur_req, " in_pkt"}, int'(in_pkt), int'(m_act));
    if (e_vld) chk({cur_req, " dout"}, int'(dout), int'(e_dout));
    if (dout_vld) rxq.push_back(dout);
    if (stuff_err) err_seen++;
  end

  // Stimulus helpers, all called at a falling edge
  logic lvl = 1'b1;
  int   tx_ones = 0;

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sym(input logic v);
    bit_stb = 1'b1; line_j = v; lvl = v;
    @(negedge clk);
    bit_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic start_pkt();
    lvl = 1'b1; line_j = 1'b1; tx_ones = 0;
    pkt_start = 1'b1;
    @(negedge clk);
    pkt_start = 1'b0;
    @(negedge clk);
  endtask

  task automatic end_pkt();
    pkt_end = 1'b1;
    @(negedge clk);
    pkt_end = 1'b0;
    @(negedge clk);
  endtask

  // Encode one data bit with stuffing after six 1s
  task automatic send_bit(input logic b);
    sym(b ? lvl : ~lvl);
    if (b) begin
      tx_ones++;
      if (tx_ones == 6) begin sym(~lvl); tx_ones = 0; end
    end else tx_ones = 0;
  endtask

  task automatic cmp_rx(input string tag, input logic exp_q[$]);
    chk({tag, " count"}, rxq.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < rxq.size(); i++)
      chk({tag, " bit"}, int'(rxq[i]), int'(exp_q[i]));
    rxq.delete();
  endtask

  initial begin
    logic q[$];
    idle_cycles(3);
    // R9: reset state
    chk("R9 dout", int'(dout), 0);
    chk("R9 dout_vld", int'(dout_vld), 0);
    chk("R9 stuff_err", int'(stuff_err), 0);
    chk("R9 in_pkt", int'(in_pkt), 0);
    rst_n = 1'b1;
    idle_cycles(2);
    chk("R9 in_pkt after reset", int'(in_pkt), 0);

    // R7: strobes outside a packet
    cur_req = "R7";
    sym(1'b0); sym(1'b1); sym(1'b1);
    chk("R7 no output while idle", rxq.size(), 0);
    rxq.delete();

    // R1 / R2: plain decode, first K gives 0
    cur_req = "R1";
    start_pkt();
    q = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
    foreach (q[i]) send_bit(q[i]);
    end_pkt();
    cmp_rx("R1", q);

    // R2: first J sample gives 1
    cur_req = "R2";
    start_pkt();
    sym(1'b1); sym(1'b0);
    end_pkt();
    q = '{1'b1, 1'b0};
    cmp_rx("R2", q);

    // R3 / R4: thirteen 1s need two stuffed bits, then 0 1
    cur_req = "R4";
    start_pkt();
    q = {};
    for (int i = 0; i < 13; i++) q.push_back(1'b1);
    q.push_back(1'b0); q.push_back(1'b1);
    foreach (q[i]) send_bit(q[i]);
    end_pkt();
    cmp_rx("R3/R4 removed stuffed bits", q);
    chk("R3 no error on valid stuffing", err_seen, 0);

    // R6: five 1s, a 0, then six 1s and a 0
    cur_req = "R6";
    start_pkt();
    q = {};
    for (int i = 0; i < 5; i++) q.push_back(1'b1);
    q.push_back(1'b0);
    for (int i = 0; i < 6; i++) q.push_back(1'b1);
    q.push_back(1'b0);
    foreach (q[i]) send_bit(q[i]);
    end_pkt();
    cmp_rx("R6 run restart", q);

    // R5: missing stuff transition aborts
    cur_req = "R5";
    start_pkt();
    for (int i = 0; i < 6; i++) sym(lvl);
    sym(lvl);
    chk("R5 error pulse count", err_seen, 1);
    chk("R5 in_pkt low after error", int'(in_pkt), 0);
    sym(~lvl); sym(lvl); sym(~lvl);
    q = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
    cmp_rx("R5 no output after abort", q);
    chk("R5 single error pulse", err_seen, 1);

    // R8: strobe coinciding with end is ignored
    cur_req = "R8";
    start_pkt();
    send_bit(1'b0); send_bit(1'b1);
    pkt_end = 1'b1; bit_stb = 1'b1; line_j = ~lvl;
    @(negedge clk);
    pkt_end = 1'b0; bit_stb = 1'b0;
    @(negedge clk);
    chk("R8 in_pkt low after end", int'(in_pkt), 0);
    sym(1'b0); sym(1'b1);
    q = '{1'b0, 1'b1};
    cmp_rx("R8 strobe at end ignored", q);

    // R8: strobe coinciding with start is ignored
    lvl = 1'b1; tx_ones = 0;
    pkt_start = 1'b1; bit_stb = 1'b1; line_j = 1'b0;
    @(negedge clk);
    pkt_start = 1'b0; bit_stb = 1'b0; line_j = 1'b1;
    @(negedge clk);
    sym(1'b0);
    end_pkt();
    q = '{1'b0};
    cmp_rx("R8 strobe at start ignored", q);

    // R10: quiet cycles without strobes in a packet
    cur_req = "R10";
    start_pkt();
    idle_cycles(10);
    chk("R10 no valid without strobe", rxq.size(), 0);
    end_pkt();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule